// File: doc/BRIEF.md
# Compact Pair Expander

This unit sits between a packet sequencer and an ordinary three-operand instruction decoder. Each 32-bit packet holds two compact instructions. The sequencer has already split them into fields: slot A and slot B, each with an opcode, register numbers and a 12-bit immediate. It also supplies a pairing category and a memory access size. The expander turns the pair into two explicit micro-operations, each with an opcode, rd, rs1, rs2 and a sign-extended 16-bit immediate. The decoder downstream never has to know that the packet was compressed.

Much of what the compact form leaves out is implied by the category. Dependent chains pass their intermediate value through a hidden temporary register, x31. Two-operand forms reuse the destination as the first source. Paired memory accesses derive the second address from the first by adding the access size. Stack adjustments scale their immediate by 16. Some two-operand operations are pointless when both operands name the same register, so those encodings are read as unary operations instead.

The result is registered: one cycle after a packet is accepted, the unit presents a valid flag and two records, or it raises an illegal-instruction flag instead.

Top module: `pair_expander`

## Requirements
- R1: Outputs are registered. A packet presented with inValid high appears on the outputs exactly one clock later. A cycle with inValid low produces outValid=0, outIllegal=0 and all-zero records in the next cycle. Reset (rst, synchronous, active high) clears every output to zero.
- R2: Generic chain, category 0:
  - Record 0 is {aOp, rd=31, rs1=aRs1, rs2=aRs2, imm=sext(aImm)}.
  - Record 1 is {bOp, rd=bRd, rs1=31, rs2=bRs2, imm=sext(bImm)}.
- R3: Memory chain, category 1. Slot B must be a load (opcode 11) or a store (opcode 12).
  - Record 0 is an address add with rd=31, rs1=aRs1, rs2=aRs2 and imm=0. Its opcode is chosen from memSize: 0 gives ADD (0), 1 gives SH1ADD (8), 2 gives SH2ADD (9), 3 gives SH3ADD (10).
  - Record 1 is as in R2.
  - Any other slot-B opcode is illegal.
- R4: Two-operand form, category 2. Each slot expands to {op, rd, rs1=rd, rs2, sext(imm)}, and slot B becomes record 1.
- R5: Unary forms, which apply under categories 2 and 6 to any slot expanded in two-operand form when rd equals rs2:
  - SUB (1) becomes negation: {SUB, rd, rs1=0, rs2=rd, 0}.
  - XOR (4) becomes bitwise not: {XORI (6), rd, rd, 0, 0xFFFF}.
  - OR (3) becomes shift-left-by-one: {SLLI (7), rd, rd, 0, 1}.
- R6: Shared-source pair, category 3. Record 0 is {aOp, aRd, aRs1, aRs2, sext(aImm)}. Record 1 is {bOp, bRd, aRs1, aRs2, sext(bImm)}, so both records read the sources coded in slot A.
- R7: Memory pair, category 4. Slot A must be a load (11) or a store (12); any other slot-A opcode is illegal.
  - Record 0 is {aOp, aRd, aRs1, aRs2, sext(aImm)}.
  - Record 1 is {aOp, bRd, aRs1, bRs2, sext(aImm) + 2^memSize}, with the addition wrapping at 16 bits.
- R8: Move pair, category 5. An opcode of ADDI (5) marks a load-immediate; any other opcode marks a move.
  - Slot A gives either {ADDI, aRd, 0, 0, sext(aImm)} or {ADD, aRd, aRs1, 0, 0}.
  - Slot B gives either {ADDI, bRd, 0, 0, sext(bImm)} or {ADD, bRd, aRs2, 0, 0}.
  - A load-immediate in slot A followed by a move in slot B is illegal.
- R9: Stack adjust, category 6. Record 0 is {ADDI, rd=2, rs1=2, rs2=0, imm=sext(aImm)*16}. Record 1 is slot B in two-operand form (R4, R5).
- R10: Category 7 and every illegal case named above give outIllegal=1, outValid=0 and all-zero records. outValid and outIllegal are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Packet fields are present this cycle |
| pairCat | input | 3 | Pairing category |
| memSize | input | 2 | log2 of the memory access size in bytes |
| aOp | input | 4 | Slot A opcode |
| aRd | input | 5 | Slot A destination |
| aRs1 | input | 5 | Slot A first source |
| aRs2 | input | 5 | Slot A second source |
| aImm | input | 12 | Slot A immediate |
| bOp | input | 4 | Slot B opcode |
| bRd | input | 5 | Slot B destination |
| bRs2 | input | 5 | Slot B second source |
| bImm | input | 12 | Slot B immediate |
| outValid | output | 1 | Records are valid |
| outIllegal | output | 1 | Packet could not be expanded |
| u0Op | output | 4 | Record 0 opcode |
| u0Rd | output | 5 | Record 0 destination |
| u0Rs1 | output | 5 | Record 0 first source |
| u0Rs2 | output | 5 | Record 0 second source |
| u0Imm | output | 16 | Record 0 immediate |
| u1Op | output | 4 | Record 1 opcode |
| u1Rd | output | 5 | Record 1 destination |
| u1Rs1 | output | 5 | Record 1 first source |
| u1Rs2 | output | 5 | Record 1 second source |
| u1Imm | output | 16 | Record 1 immediate |

## Verification
The bench targets the places where an inferred field is easy to get wrong.

- **Memory pair.** A negative offset plus the access size wraps to zero. An expander that forgot to sign-extend, or that added the size to the wrong record, would give a second address that is off by a large amount.
- **Chains.** A design that took slot B's own first source instead of x31 would break the data flow inside the chain. One that picked the shift amount from the wrong size would scale the address incorrectly.
- **Same-register operands.** These are exercised under both the two-operand and stack categories, so a unary rewrite wired to only one slot or one category shows up at once.
- **Illegal combinations.** The load-immediate-then-move pair and a non-memory opcode in a memory category are sent, to confirm that the design raises the illegal flag and clears the records instead of letting a plausible but wrong pair through.

// File: rtl/pair_expander_pkg.sv
package pair_expander_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD    = 4'd0,
    OP_SUB    = 4'd1,
    OP_AND    = 4'd2,
    OP_OR     = 4'd3,
    OP_XOR    = 4'd4,
    OP_ADDI   = 4'd5,
    OP_XORI   = 4'd6,
    OP_SLLI   = 4'd7,
    OP_SH1ADD = 4'd8,
    OP_SH2ADD = 4'd9,
    OP_SH3ADD = 4'd10,
    OP_LOAD   = 4'd11,
    OP_STORE  = 4'd12,
    OP_MUL    = 4'd13,
    OP_MULH   = 4'd14,
    OP_RSVD   = 4'd15
  } uop_op_e;

  typedef enum logic [2:0] {
    CAT_CHAIN     = 3'd0,
    CAT_CHAIN_MEM = 3'd1,
    CAT_TWO_OP    = 3'd2,
    CAT_SHARED    = 3'd3,
    CAT_MEM_PAIR  = 3'd4,
    CAT_MOVE_PAIR = 3'd5,
    CAT_SP_ADJ    = 3'd6,
    CAT_RSVD      = 3'd7
  } pair_cat_e;

  // Strobes from control to datapath: one-hot category select plus qualifiers.
  typedef struct packed {
    logic chain;
    logic chainMem;
    logic twoOp;
    logic shared;
    logic memPair;
    logic movePair;
    logic spAdj;
    logic illegal;
    logic aLi;
    logic bLi;
  } pair_strobe_t;

  function automatic logic isMemOp(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_STORE);
  endfunction

endpackage

// File: rtl/pair_expander_ctrl.sv
module pair_expander_ctrl
  import pair_expander_pkg::*;
(
  input  logic [2:0]      pairCat,
  input  logic [OP_W-1:0] aOp,
  input  logic [OP_W-1:0] bOp,
  output pair_strobe_t    stb
);

  always_comb begin
    stb          = '0;
    stb.aLi      = (aOp == OP_ADDI);
    stb.bLi      = (bOp == OP_ADDI);
    unique case (pairCat)
      CAT_CHAIN:     stb.chain    = 1'b1;
      CAT_CHAIN_MEM: begin
        stb.chainMem = 1'b1;
        stb.illegal  = !isMemOp(bOp);
      end
      CAT_TWO_OP:    stb.twoOp    = 1'b1;
      CAT_SHARED:    stb.shared   = 1'b1;
      CAT_MEM_PAIR:  begin
        stb.memPair  = 1'b1;
        stb.illegal  = !isMemOp(aOp);
      end
      CAT_MOVE_PAIR: begin
        stb.movePair = 1'b1;
        stb.illegal  = stb.aLi && !stb.bLi;
      end
      CAT_SP_ADJ:    stb.spAdj    = 1'b1;
      default:       stb.illegal  = 1'b1;
    endcase
  end

endmodule

// File: rtl/pair_expander_dp.sv
module pair_expander_dp
  import pair_expander_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int CIMM_W   = 12,
  parameter int IMM_W    = 16,
  parameter int SIZE_W   = 2,
  parameter int TMP_REG  = 31,
  parameter int SP_REG   = 2,
  parameter int SP_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  pair_strobe_t      stb,
  input  logic [SIZE_W-1:0] memSize,
  input  logic [OP_W-1:0]   aOp,
  input  logic [REG_W-1:0]  aRd,
  input  logic [REG_W-1:0]  aRs1,
  input  logic [REG_W-1:0]  aRs2,
  input  logic [CIMM_W-1:0] aImm,
  input  logic [OP_W-1:0]   bOp,
  input  logic [REG_W-1:0]  bRd,
  input  logic [REG_W-1:0]  bRs2,
  input  logic [CIMM_W-1:0] bImm,
  output logic              outValid,
  output logic              outIllegal,
  output logic [OP_W-1:0]   u0Op,
  output logic [REG_W-1:0]  u0Rd,
  output logic [REG_W-1:0]  u0Rs1,
  output logic [REG_W-1:0]  u0Rs2,
  output logic [IMM_W-1:0]  u0Imm,
  output logic [OP_W-1:0]   u1Op,
  output logic [REG_W-1:0]  u1Rd,
  output logic [REG_W-1:0]  u1Rs1,
  output logic [REG_W-1:0]  u1Rs2,
  output logic [IMM_W-1:0]  u1Imm
);

  localparam int EXT_W = IMM_W - CIMM_W;
  localparam int REC_W = OP_W + 3 * REG_W + IMM_W;
  localparam logic [REG_W-1:0] TMP = REG_W'(TMP_REG);
  localparam logic [REG_W-1:0] SP  = REG_W'(SP_REG);

  logic [IMM_W-1:0] aImmX, bImmX, sizeBytes;
  assign aImmX     = {{EXT_W{aImm[CIMM_W-1]}}, aImm};
  assign bImmX     = {{EXT_W{bImm[CIMM_W-1]}}, bImm};
  assign sizeBytes = IMM_W'(1) << memSize;

  // Per-slot two-operand expansion, including the same-register unary rewrites.
  logic [OP_W-1:0]  sOp  [2];
  logic [REG_W-1:0] sRd  [2];
  logic [REG_W-1:0] sRs2 [2];
  logic [IMM_W-1:0] sImm [2];
  assign sOp[0] = aOp;   assign sOp[1] = bOp;
  assign sRd[0] = aRd;   assign sRd[1] = bRd;
  assign sRs2[0] = aRs2; assign sRs2[1] = bRs2;
  assign sImm[0] = aImmX; assign sImm[1] = bImmX;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic [REC_W-1:0] rec;
    always_comb begin
      rec = {sOp[g], sRd[g], sRd[g], sRs2[g], sImm[g]};
      if (sRd[g] == sRs2[g]) begin
        unique case (sOp[g])
          OP_SUB:  rec = {OP_SUB, sRd[g], REG_W'(0), sRd[g], IMM_W'(0)};
          OP_XOR:  rec = {OP_XORI, sRd[g], sRd[g], REG_W'(0), {IMM_W{1'b1}}};
          OP_OR:   rec = {OP_SLLI, sRd[g], sRd[g], REG_W'(0), IMM_W'(1)};
          default: ;
        endcase
      end
    end
  end

  logic [OP_W-1:0] shAddOp;
  always_comb begin
    unique case (memSize)
      SIZE_W'(0): shAddOp = OP_ADD;
      SIZE_W'(1): shAddOp = OP_SH1ADD;
      SIZE_W'(2): shAddOp = OP_SH2ADD;
      default:    shAddOp = OP_SH3ADD;
    endcase
  end

  logic [REC_W-1:0] n0, n1;
  logic             nValid, nIll;

  always_comb begin
    n0     = '0;
    n1     = '0;
    nValid = 1'b0;
    nIll   = 1'b0;
    if (inValid) begin
      if (stb.illegal) begin
        nIll = 1'b1;
      end else begin
        nValid = 1'b1;
        if (stb.chain || stb.chainMem) begin
          n0 = stb.chainMem ? {shAddOp, TMP, aRs1, aRs2, IMM_W'(0)}
                            : {aOp, TMP, aRs1, aRs2, aImmX};
          n1 = {bOp, bRd, TMP, bRs2, bImmX};
        end else if (stb.twoOp) begin
          n0 = g_slot[0].rec;
          n1 = g_slot[1].rec;
        end else if (stb.shared) begin
          n0 = {aOp, aRd, aRs1, aRs2, aImmX};
          n1 = {bOp, bRd, aRs1, aRs2, bImmX};
        end else if (stb.memPair) begin
          n0 = {aOp, aRd, aRs1, aRs2, aImmX};
          n1 = {aOp, bRd, aRs1, bRs2, aImmX + sizeBytes};
        end else if (stb.movePair) begin
          n0 = stb.aLi ? {OP_ADDI, aRd, REG_W'(0), REG_W'(0), aImmX}
                       : {OP_ADD, aRd, aRs1, REG_W'(0), IMM_W'(0)};
          n1 = stb.bLi ? {OP_ADDI, bRd, REG_W'(0), REG_W'(0), bImmX}
                       : {OP_ADD, bRd, aRs2, REG_W'(0), IMM_W'(0)};
        end else if (stb.spAdj) begin
          n0 = {OP_ADDI, SP, SP, REG_W'(0), aImmX << SP_SHIFT};
          n1 = g_slot[1].rec;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      {u0Op, u0Rd, u0Rs1, u0Rs2, u0Imm} <= '0;
      {u1Op, u1Rd, u1Rs1, u1Rs2, u1Imm} <= '0;
    end else begin
      outValid   <= nValid;
      outIllegal <= nIll;
      {u0Op, u0Rd, u0Rs1, u0Rs2, u0Imm} <= n0;
      {u1Op, u1Rd, u1Rs1, u1Rs2, u1Imm} <= n1;
    end
  end

endmodule

// File: rtl/pair_expander.sv
module pair_expander
  import pair_expander_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int CIMM_W   = 12,
  parameter int IMM_W    = 16,
  parameter int SIZE_W   = 2,
  parameter int TMP_REG  = 31,
  parameter int SP_REG   = 2,
  parameter int SP_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [2:0]        pairCat,
  input  logic [SIZE_W-1:0] memSize,
  input  logic [OP_W-1:0]   aOp,
  input  logic [REG_W-1:0]  aRd,
  input  logic [REG_W-1:0]  aRs1,
  input  logic [REG_W-1:0]  aRs2,
  input  logic [CIMM_W-1:0] aImm,
  input  logic [OP_W-1:0]   bOp,
  input  logic [REG_W-1:0]  bRd,
  input  logic [REG_W-1:0]  bRs2,
  input  logic [CIMM_W-1:0] bImm,
  output logic              outValid,
  output logic              outIllegal,
  output logic [OP_W-1:0]   u0Op,
  output logic [REG_W-1:0]  u0Rd,
  output logic [REG_W-1:0]  u0Rs1,
  output logic [REG_W-1:0]  u0Rs2,
  output logic [IMM_W-1:0]  u0Imm,
  output logic [OP_W-1:0]   u1Op,
  output logic [REG_W-1:0]  u1Rd,
  output logic [REG_W-1:0]  u1Rs1,
  output logic [REG_W-1:0]  u1Rs2,
  output logic [IMM_W-1:0]  u1Imm
);

  pair_strobe_t stb;

  pair_expander_ctrl u_ctrl (
    .pairCat (pairCat),
    .aOp     (aOp),
    .bOp     (bOp),
    .stb     (stb)
  );

  pair_expander_dp #(
    .REG_W(REG_W), .CIMM_W(CIMM_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W),
    .TMP_REG(TMP_REG), .SP_REG(SP_REG), .SP_SHIFT(SP_SHIFT)
  ) u_dp (
    .clk(clk), .rst(rst), .inValid(inValid), .stb(stb), .memSize(memSize),
    .aOp(aOp), .aRd(aRd), .aRs1(aRs1), .aRs2(aRs2), .aImm(aImm),
    .bOp(bOp), .bRd(bRd), .bRs2(bRs2), .bImm(bImm),
    .outValid(outValid), .outIllegal(outIllegal),
    .u0Op(u0Op), .u0Rd(u0Rd), .u0Rs1(u0Rs1), .u0Rs2(u0Rs2), .u0Imm(u0Imm),
    .u1Op(u1Op), .u1Rd(u1Rd), .u1Rs1(u1Rs1), .u1Rs2(u1Rs2), .u1Imm(u1Imm)
  );

endmodule

// File: rtl/pair_expander_chk.sv
module pair_expander_chk
  import pair_expander_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int CIMM_W   = 12,
  parameter int IMM_W    = 16,
  parameter int SIZE_W   = 2,
  parameter int TMP_REG  = 31,
  parameter int SP_REG   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [2:0]        pairCat,
  input logic [SIZE_W-1:0] memSize,
  input logic [OP_W-1:0]   aOp,
  input logic [CIMM_W-1:0] aImm,
  input logic              outValid,
  input logic              outIllegal,
  input logic [REG_W-1:0]  u0Rd,
  input logic [REG_W-1:0]  u0Rs1,
  input logic [REG_W-1:0]  u0Rs2,
  input logic [IMM_W-1:0]  u0Imm,
  input logic [REG_W-1:0]  u1Rs1,
  input logic [REG_W-1:0]  u1Rs2,
  input logic [IMM_W-1:0]  u1Imm
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !outIllegal));

  p_chain_tmp_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && pairCat == CAT_CHAIN) |=>
      (outValid && u0Rd == REG_W'(TMP_REG) && u1Rs1 == REG_W'(TMP_REG)));

  p_shared_src_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && pairCat == CAT_SHARED) |=> (u0Rs1 == u1Rs1 && u0Rs2 == u1Rs2));

  p_pair_offset_r7: assert property (@(posedge clk) disable iff (rst)
    (inValid && pairCat == CAT_MEM_PAIR && isMemOp(aOp)) |=>
      (u1Imm == u0Imm + (IMM_W'(1) << $past(memSize))));

  p_sp_scale_r9: assert property (@(posedge clk) disable iff (rst)
    (inValid && pairCat == CAT_SP_ADJ) |=>
      (u0Rd == REG_W'(SP_REG) && u0Rs1 == REG_W'(SP_REG) && u0Imm[3:0] == 4'd0));

  p_flag_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outIllegal));

  p_rsvd_cat_r10: assert property (@(posedge clk) disable iff (rst)
    (inValid && pairCat == CAT_RSVD) |=> (outIllegal && u0Rs2 == '0));

endmodule

bind pair_expander pair_expander_chk #(
  .REG_W(REG_W), .CIMM_W(CIMM_W), .IMM_W(IMM_W), .SIZE_W(SIZE_W),
  .TMP_REG(TMP_REG), .SP_REG(SP_REG)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .pairCat(pairCat), .memSize(memSize),
  .aOp(aOp), .aImm(aImm), .outValid(outValid), .outIllegal(outIllegal),
  .u0Rd(u0Rd), .u0Rs1(u0Rs1), .u0Rs2(u0Rs2), .u0Imm(u0Imm),
  .u1Rs1(u1Rs1), .u1Rs2(u1Rs2), .u1Imm(u1Imm)
);

// File: tb/pair_expander_test.sv
`timescale 1ns/1ps
module pair_expander_test;
  import pair_expander_pkg::*;

  typedef struct packed {
    logic [3:0]  op;
    logic [4:0]  rd;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [15:0] imm;
  } rec_t;

  typedef struct {
    logic  v;
    logic  ill;
    rec_t  r0;
    rec_t  r1;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [2:0] pairCat = '0;
  logic [1:0] memSize = '0;
  logic [3:0] aOp = '0, bOp = '0;
  logic [4:0] aRd = '0, aRs1 = '0, aRs2 = '0, bRd = '0, bRs2 = '0;
  logic [11:0] aImm = '0, bImm = '0;
  logic outValid, outIllegal;
  logic [3:0] u0Op, u1Op;
  logic [4:0] u0Rd, u0Rs1, u0Rs2, u1Rd, u1Rs1, u1Rs2;
  logic [15:0] u0Imm, u1Imm;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  pair_expander uut (
    .clk(clk), .rst(rst), .inValid(inValid), .pairCat(pairCat), .memSize(memSize),
    .aOp(aOp), .aRd(aRd), .aRs1(aRs1), .aRs2(aRs2), .aImm(aImm),
    .bOp(bOp), .bRd(bRd), .bRs2(bRs2), .bImm(bImm),
    .outValid(outValid), .outIllegal(outIllegal),
    .u0Op(u0Op), .u0Rd(u0Rd), .u0Rs1(u0Rs1), .u0Rs2(u0Rs2), .u0Imm(u0Imm),
    .u1Op(u1Op), .u1Rd(u1Rd), .u1Rs1(u1Rs1), .u1Rs2(u1Rs2), .u1Imm(u1Imm)
  );

  function automatic rec_t mk(input logic [3:0] op, input logic [4:0] rd,
                              input logic [4:0] rs1, input logic [4:0] rs2,
                              input logic [15:0] imm);
    return '{op: op, rd: rd, rs1: rs1, rs2: rs2, imm: imm};
  endfunction

  localparam rec_t ZR = '0;

  // Driver: apply one packet at the falling edge and queue its expected result.
  task automatic send(input logic v, input logic [2:0] cat, input logic [1:0] sz,
                      input logic [3:0] ao, input logic [4:0] ard, input logic [4:0] ars1,
                      input logic [4:0] ars2, input logic [11:0] aim,
                      input logic [3:0] bo, input logic [4:0] brd, input logic [4:0] brs2,
                      input logic [11:0] bim,
                      input logic ev, input logic eill, input rec_t e0, input rec_t e1,
                      input string tag);
    exp_t e;
    @(negedge clk);
    inValid = v; pairCat = cat; memSize = sz;
    aOp = ao; aRd = ard; aRs1 = ars1; aRs2 = ars2; aImm = aim;
    bOp = bo; bRd = brd; bRs2 = brs2; bImm = bim;
    e.v = ev; e.ill = eill; e.r0 = e0; e.r1 = e1; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare just after each rising edge against the oldest expectation.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      rec_t a0, a1;
      e = q.pop_front();
      a0 = {u0Op, u0Rd, u0Rs1, u0Rs2, u0Imm};
      a1 = {u1Op, u1Rd, u1Rs1, u1Rs2, u1Imm};
      checks++;
      if (outValid !== e.v || outIllegal !== e.ill || a0 !== e.r0 || a1 !== e.r1) begin
        failures++;
        $display("FAIL %s: actual v=%b ill=%b r0=%h r1=%h expected v=%b ill=%b r0=%h r1=%h",
                 e.tag, outValid, outIllegal, a0, a1, e.v, e.ill, e.r0, e.r1);
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++; // R1 reset state
    if (outValid !== 1'b0 || outIllegal !== 1'b0 || u0Imm !== '0 || u1Rd !== '0) begin
      failures++;
      $display("FAIL R1 reset: actual v=%b ill=%b expected v=0 ill=0", outValid, outIllegal);
    end
    @(negedge clk); rst = 1'b0;

    // R2 generic chain: x31 hidden temporary
    send(1, 3'd0, 0, OP_ADD, 5'd1, 5'd5, 5'd6, 12'd0, OP_SUB, 5'd7, 5'd8, 12'd3,
         1, 0, mk(OP_ADD, 31, 5, 6, 0), mk(OP_SUB, 7, 31, 8, 3), "R2 chain");
    // R1 idle cycle gives quiet outputs
    send(0, 3'd0, 0, OP_ADD, 5'd1, 5'd5, 5'd6, 12'd0, OP_SUB, 5'd7, 5'd8, 12'd3,
         0, 0, ZR, ZR, "R1 idle");
    // R3 memory chain, word size picks SH2ADD
    send(1, 3'd1, 2, OP_ADD, 5'd9, 5'd3, 5'd4, 12'd77, OP_LOAD, 5'd10, 5'd0, 12'd8,
         1, 0, mk(OP_SH2ADD, 31, 3, 4, 0), mk(OP_LOAD, 10, 31, 0, 8), "R3 chainmem size2");
    // R3 byte size picks plain ADD
    send(1, 3'd1, 0, OP_ADD, 5'd9, 5'd3, 5'd4, 12'd0, OP_STORE, 5'd0, 5'd12, 12'hFFC,
         1, 0, mk(OP_ADD, 31, 3, 4, 0), mk(OP_STORE, 0, 31, 12, 16'hFFFC), "R3 chainmem size0");
    // R3 non-memory second op is illegal
    send(1, 3'd1, 1, OP_ADD, 5'd9, 5'd3, 5'd4, 12'd0, OP_ADD, 5'd10, 5'd0, 12'd0,
         0, 1, ZR, ZR, "R3 chainmem illegal");
    // R4 two-operand with negative immediate, R5 negation in slot B
    send(1, 3'd2, 0, OP_ADDI, 5'd4, 5'd20, 5'd0, 12'hFFD, OP_SUB, 5'd6, 5'd6, 12'd0,
         1, 0, mk(OP_ADDI, 4, 4, 0, 16'hFFFD), mk(OP_SUB, 6, 0, 6, 0), "R4/R5 twoop neg");
    // R5 not in slot A, shift-by-one in slot B
    send(1, 3'd2, 0, OP_XOR, 5'd3, 5'd9, 5'd3, 12'd0, OP_OR, 5'd5, 5'd5, 12'd0,
         1, 0, mk(OP_XORI, 3, 3, 0, 16'hFFFF), mk(OP_SLLI, 5, 5, 0, 1), "R5 unary not/slli");
    // R4 plain two-operand, different registers stay binary
    send(1, 3'd2, 0, OP_XOR, 5'd3, 5'd9, 5'd8, 12'd0, OP_OR, 5'd5, 5'd1, 12'd0,
         1, 0, mk(OP_XOR, 3, 3, 8, 0), mk(OP_OR, 5, 5, 1, 0), "R4 twoop binary");
    // R6 shared sources
    send(1, 3'd3, 0, OP_MUL, 5'd1, 5'd11, 5'd12, 12'd0, OP_MULH, 5'd13, 5'd21, 12'd0,
         1, 0, mk(OP_MUL, 1, 11, 12, 0), mk(OP_MULH, 13, 11, 12, 0), "R6 shared");
    // R7 load pair, doubleword
    send(1, 3'd4, 3, OP_LOAD, 5'd5, 5'd2, 5'd0, 12'd16, OP_ADD, 5'd6, 5'd0, 12'd99,
         1, 0, mk(OP_LOAD, 5, 2, 0, 16), mk(OP_LOAD, 6, 2, 0, 24), "R7 load pair");
    // R7 store pair, negative offset wraps to zero
    send(1, 3'd4, 1, OP_STORE, 5'd0, 5'd8, 5'd9, 12'hFFE, OP_ADD, 5'd0, 5'd10, 12'd0,
         1, 0, mk(OP_STORE, 0, 8, 9, 16'hFFFE), mk(OP_STORE, 0, 8, 10, 0), "R7 store pair wrap");
    // R7 non-memory first op is illegal
    send(1, 3'd4, 1, OP_ADD, 5'd1, 5'd8, 5'd9, 12'd4, OP_ADD, 5'd2, 5'd10, 12'd0,
         0, 1, ZR, ZR, "R7 mempair illegal");
    // R8 mv/mv
    send(1, 3'd5, 0, OP_ADD, 5'd3, 5'd4, 5'd5, 12'd0, OP_ADD, 5'd6, 5'd0, 12'd0,
         1, 0, mk(OP_ADD, 3, 4, 0, 0), mk(OP_ADD, 6, 5, 0, 0), "R8 mv/mv");
    // R8 li/li
    send(1, 3'd5, 0, OP_ADDI, 5'd3, 5'd4, 5'd5, 12'd7, OP_ADDI, 5'd6, 5'd0, 12'hFFF,
         1, 0, mk(OP_ADDI, 3, 0, 0, 7), mk(OP_ADDI, 6, 0, 0, 16'hFFFF), "R8 li/li");
    // R8 mv/li
    send(1, 3'd5, 0, OP_ADD, 5'd3, 5'd4, 5'd5, 12'd7, OP_ADDI, 5'd6, 5'd0, 12'd9,
         1, 0, mk(OP_ADD, 3, 4, 0, 0), mk(OP_ADDI, 6, 0, 0, 9), "R8 mv/li");
    // R8 li/mv is illegal
    send(1, 3'd5, 0, OP_ADDI, 5'd3, 5'd4, 5'd5, 12'd7, OP_ADD, 5'd6, 5'd0, 12'd9,
         0, 1, ZR, ZR, "R8 li/mv illegal");
    // R9 stack adjust, negative
    send(1, 3'd6, 0, OP_ADD, 5'd9, 5'd9, 5'd9, 12'hFFE, OP_ADD, 5'd10, 5'd11, 12'd0,
         1, 0, mk(OP_ADDI, 2, 2, 0, 16'hFFE0), mk(OP_ADD, 10, 10, 11, 0), "R9 sp neg");
    // R9 stack adjust positive with R5 unary in slot B
    send(1, 3'd6, 0, OP_ADD, 5'd0, 5'd0, 5'd0, 12'd5, OP_SUB, 5'd7, 5'd7, 12'd0,
         1, 0, mk(OP_ADDI, 2, 2, 0, 16'd80), mk(OP_SUB, 7, 0, 7, 0), "R9/R5 sp pos");
    // R10 reserved category
    send(1, 3'd7, 0, OP_ADD, 5'd1, 5'd2, 5'd3, 12'd4, OP_ADD, 5'd5, 5'd6, 12'd7,
         0, 1, ZR, ZR, "R10 reserved cat");
    // R1 idle after illegal clears the flag
    send(0, 3'd7, 0, OP_ADD, 5'd1, 5'd2, 5'd3, 12'd4, OP_ADD, 5'd5, 5'd6, 12'd7,
         0, 0, ZR, ZR, "R1 idle after illegal");

    @(negedge clk); inValid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule